// File: doc/BRIEF.md
# Configuration Frame Error Checker

This block watches a serial configuration bitstream, one bit per clock when `bit_vld` is high, and checks the framing of every frame. A frame opens with a start pair (a 0 followed by a 1). The payload is `PAYLOAD_BITS` long and is sent MSB first. A checksum byte follows it, then a run of eight stop bits. A sideband input `frame_kind`, sampled on the start pair, says whether the frame carries data, an address or the device identity. Three checks run on each frame. The checksum byte must equal the XOR of the payload's whole bytes. An identity frame must carry the expected device code. The stop run that closed the previous frame must be all ones, and this is judged when the next start pair arrives.

The first error moves the state machine into a halt state. The halt state drives `init_n` low, latches a 2-bit error code into a status register and ignores the stream from then on. Only `rst_n`, the `prog` pin or a program command written over the host register port brings it back to hunting for a start pair. Each frame that passes raises `frame_ok` for one cycle.

States: HUNT (idle, waiting for a 0), SYNC (saw a 0, waiting for the 1), BODY (payload bits), CSUM (checksum bits), STOP (stop run), HALT (error parked). Transitions: HUNT→SYNC on a valid 0. SYNC→BODY on a valid 1 when the last stop run was clean. SYNC→HALT on a valid 1 when that run had a 0. BODY→CSUM after the last payload bit. CSUM→STOP on a pass. CSUM→HALT on a checksum or identity mismatch. STOP→HUNT after the eighth stop bit. Any state→HUNT on a restart.

Top module: `cfg_frame_checker`

## Requirements
- R1: After reset, `init_n` is 1, `err_code` is 00, `frame_ok` is 0 and a status read returns 0.
- R2: A frame begins at the first valid 1 that follows a valid 0. Idle ones before it, and repeated zeros before the 1, are accepted.
- R3: The checksum byte follows the payload MSB first and must equal the XOR of the payload's complete bytes (MSB first). Trailing payload bits that do not fill a byte are left out. A mismatch latches code 11.
- R4: In a frame with `frame_kind` = 10 (identity), the first `ID_W` payload bits (MSB first) must equal `ID_CODE`, or code 01 is latched. Kinds 00 (data) and 01 (address) get no code compare.
- R5: When a start pair completes and any of the eight stop bits that followed the previous frame's checksum was 0, code 10 is latched.
- R6: A frame that passes both its checksum and identity checks raises `frame_ok` for exactly one cycle. The pulse comes in the cycle after the last checksum bit is sampled.
- R7: On an error, `init_n` goes low and `err_code` takes the code in the cycle after the deciding bit. Later bits neither change the code nor raise `frame_ok`, so only the first error is kept.
- R8: A high `prog` pin clears the error code, raises `init_n`, forgets any bad stop run and restarts hunting at the next edge.
- R9: A host write of value 8'h01 to address 1 restarts the checker in the same way as `prog`. A read of address 0 returns {6'b0, err_code}.
- R10: When a frame has both a checksum and an identity mismatch, the checksum code 11 is the one latched.
- R11: Cycles with `bit_vld` low are ignored, whatever is on `bit_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog | input | 1 | Program request: clears the error and restarts |
| bit_vld | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial bitstream |
| frame_kind | input | 2 | 00 data, 01 address, 10 identity; sampled at the start pair |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 1 | Host address: 0 status, 1 control |
| reg_wdata | input | 8 | Host write data (8'h01 to control = program) |
| reg_rdata | output | 8 | Host read data |
| init_n | output | 1 | Low while parked on an error |
| frame_ok | output | 1 | One-cycle pulse per passing frame |
| err_code | output | 2 | 00 none, 01 identity, 10 alignment, 11 checksum |

## Verification
The assertions take for granted that frames are at least a few cycles apart, which keeps `frame_ok` a single-cycle pulse. They also assume that restart requests and the stream do not need any ordering between them, since a restart always wins over an error. The stimulus holds `frame_kind` steady for a whole frame. It raises `prog` and host writes only between frames and holds them for one cycle at a time. Stall cycles put the complemented bit on `bit_in`, so a checker that wrongly takes ignored bits would fail.

// File: rtl/cfg_fc_pkg.sv
package cfg_fc_pkg;
    typedef enum logic [2:0] {
        S_HUNT, S_SYNC, S_BODY, S_CSUM, S_STOP, S_HALT
    } fc_state_e;

    typedef enum logic [1:0] {
        E_NONE  = 2'b00,
        E_ID    = 2'b01,
        E_ALIGN = 2'b10,
        E_CSUM  = 2'b11
    } fc_err_e;

    typedef enum logic [1:0] {
        K_DATA = 2'b00,
        K_ADDR = 2'b01,
        K_ID   = 2'b10,
        K_RSVD = 2'b11
    } fc_kind_e;

    localparam int TRAIL_BITS = 8;
    localparam logic [7:0] CMD_PROG = 8'h01;
endpackage

// File: rtl/cfg_fc_bytes.sv
module cfg_fc_bytes #(
    parameter int ID_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift,
    input  logic            din,
    output logic [7:0]      xor_acc,
    output logic [ID_W-1:0] id_word
);
    localparam int IDC_W = $clog2(ID_W + 1);
    localparam logic [IDC_W-1:0] ID_LIM = IDC_W'(ID_W);

    logic [6:0]       part;
    logic [2:0]       idx;
    logic [IDC_W-1:0] id_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            part    <= '0;
            idx     <= '0;
            xor_acc <= '0;
            id_word <= '0;
            id_cnt  <= '0;
        end else if (shift) begin
            part <= {part[5:0], din};
            idx  <= idx + 3'd1;
            if (idx == 3'd7)
                xor_acc <= xor_acc ^ {part, din};
            if (id_cnt < ID_LIM) begin
                id_word <= {id_word[ID_W-2:0], din};
                id_cnt  <= id_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_fc_regs.sv
module cfg_fc_regs
    import cfg_fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       set_err,
    input  fc_err_e    err_in,
    output logic       restart,
    output fc_err_e    err_q,
    output logic [7:0] reg_rdata
);
    assign restart   = prog | (reg_wr & reg_addr & (reg_wdata == CMD_PROG));
    assign reg_rdata = reg_addr ? 8'h00 : {6'b0, err_q};

    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            err_q <= E_NONE;
        else if (set_err && err_q == E_NONE)
            err_q <= err_in;
    end
endmodule

// File: rtl/cfg_frame_checker.sv
module cfg_frame_checker
    import cfg_fc_pkg::*;
#(
    parameter int              PAYLOAD_BITS = 1240,
    parameter int              ID_W         = 32,
    parameter logic [ID_W-1:0] ID_CODE      = 32'h5A3C_0F96
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog,
    input  logic       bit_vld,
    input  logic       bit_in,
    input  logic [1:0] frame_kind,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       init_n,
    output logic       frame_ok,
    output logic [1:0] err_code
);
    localparam int CNT_W = $clog2(PAYLOAD_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_PAY  = CNT_W'(PAYLOAD_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_TAIL = CNT_W'(TRAIL_BITS - 1);

    fc_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    fc_kind_e        kind_q;
    logic [6:0]      csum_sr;
    logic            stop_bad;
    logic            start_ok, pass, err_set, restart;
    fc_err_e         err_kind, err_q;
    logic [7:0]      xor_acc;
    logic [ID_W-1:0] id_word;

    cfg_fc_bytes #(.ID_W(ID_W)) u_bytes (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_ok),
        .shift   (state == S_BODY && bit_vld),
        .din     (bit_in),
        .xor_acc (xor_acc),
        .id_word (id_word)
    );

    cfg_fc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog      (prog),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .set_err   (err_set),
        .err_in    (err_kind),
        .restart   (restart),
        .err_q     (err_q),
        .reg_rdata (reg_rdata)
    );

    // next-state decode
    always_comb begin
        nxt      = state;
        start_ok = 1'b0;
        pass     = 1'b0;
        err_set  = 1'b0;
        err_kind = E_NONE;
        unique case (state)
            S_HUNT: if (bit_vld && !bit_in) nxt = S_SYNC;
            S_SYNC: if (bit_vld && bit_in) begin
                if (stop_bad) begin
                    nxt      = S_HALT;
                    err_set  = 1'b1;
                    err_kind = E_ALIGN;
                end else begin
                    nxt      = S_BODY;
                    start_ok = 1'b1;
                end
            end
            S_BODY: if (bit_vld && cnt == LAST_PAY) nxt = S_CSUM;
            S_CSUM: if (bit_vld && cnt == LAST_TAIL) begin
                if ({csum_sr, bit_in} != xor_acc) begin
                    nxt      = S_HALT;
                    err_set  = 1'b1;
                    err_kind = E_CSUM;
                end else if (kind_q == K_ID && id_word != ID_CODE) begin
                    nxt      = S_HALT;
                    err_set  = 1'b1;
                    err_kind = E_ID;
                end else begin
                    nxt  = S_STOP;
                    pass = 1'b1;
                end
            end
            S_STOP: if (bit_vld && cnt == LAST_TAIL) nxt = S_HUNT;
            S_HALT: nxt = S_HALT;
            default: nxt = S_HUNT;
        endcase
    end

    // state register and per-frame context
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state    <= S_HUNT;
            cnt      <= '0;
            kind_q   <= K_DATA;
            csum_sr  <= '0;
            stop_bad <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state)
                cnt <= '0;
            else if (bit_vld)
                cnt <= cnt + 1'b1;
            if (start_ok)
                kind_q <= fc_kind_e'(frame_kind);
            if (state == S_CSUM && bit_vld)
                csum_sr <= {csum_sr[5:0], bit_in};
            if (start_ok)
                stop_bad <= 1'b0;
            else if (state == S_STOP && bit_vld && !bit_in)
                stop_bad <= 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            frame_ok <= 1'b0;
        else
            frame_ok <= pass;
    end

    assign init_n   = (state != S_HALT);
    assign err_code = err_q;
endmodule

// File: rtl/cfg_fc_chk.sv
module cfg_fc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prog,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic       init_n,
    input logic       frame_ok,
    input logic [1:0] err_code
);
    logic rq;
    assign rq = prog | (reg_wr & reg_addr & (reg_wdata == 8'h01));

    p_init_tracks_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_n == (err_code == 2'b00));

    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'b00 && !rq) |=> $stable(err_code));

    // R8 and R9: both restart paths
    p_restart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rq |=> (err_code == 2'b00 && init_n && !frame_ok));

    p_ok_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> !frame_ok);

    p_ok_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> init_n);
endmodule

bind cfg_frame_checker cfg_fc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog      (prog),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .init_n    (init_n),
    .frame_ok  (frame_ok),
    .err_code  (err_code)
);

// File: tb/cfg_frame_checker_tb.sv
module cfg_frame_checker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b1;
    logic [1:0] frame_kind = 2'b00;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       init_n, frame_ok;
    logic [1:0] err_code;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int exp_q[$];
    logic [1:0] prev_err = 2'b00;

    always #10 clk = ~clk;

    cfg_frame_checker #(.PAYLOAD_BITS(44), .ID_W(16), .ID_CODE(16'hC3A5)) u_dut (
        .clk(clk), .rst_n(rst_n), .prog(prog), .bit_vld(bit_vld), .bit_in(bit_in),
        .frame_kind(frame_kind), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .init_n(init_n),
        .frame_ok(frame_ok), .err_code(err_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input int code);
        case (code)
            0: return "R6 frame pass";
            1: return "R4 id code";
            2: return "R5 stop run";
            default: return "R3 checksum";
        endcase
    endfunction

    task automatic observe(input int got);
        if (exp_q.size() == 0)
            chk(0, "R7 unexpected result", got, -1);
        else begin
            int e = exp_q.pop_front();
            chk(got == e, req_of(e), got, e);
        end
    endtask

    // monitor: scoreboard side
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_ok) observe(0);
            if (err_code != 2'b00 && prev_err == 2'b00) observe(int'(err_code));
        end
        prev_err = err_code;
    end

    task automatic put_bit(input logic b, input bit gap);
        if (gap) begin
            @(negedge clk);
            bit_vld = 1'b0;
            bit_in  = ~b;   // R11: junk on stalled cycles
        end
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
    endtask

    // driver: builds a frame and pushes its expected result
    task automatic send_frame(input logic [1:0] kind, input logic [39:0] body,
                              input logic [7:0] flip, input logic [7:0] stop_pat,
                              input bit gaps, input bit dbl_zero, input int exp);
        logic [7:0] cs;
        cs = body[39:32] ^ body[31:24] ^ body[23:16] ^ body[15:8] ^ body[7:0];
        cs = cs ^ flip;
        if (exp >= 0) exp_q.push_back(exp);
        frame_kind = kind;
        put_bit(1'b1, 0);
        put_bit(1'b1, 0);
        if (dbl_zero) put_bit(1'b0, gaps);
        put_bit(1'b0, gaps);
        put_bit(1'b1, gaps);
        for (int i = 39; i >= 0; i--) put_bit(body[i], gaps);
        for (int i = 3; i >= 0; i--) put_bit(i[0], gaps);   // partial byte, not summed
        for (int i = 7; i >= 0; i--) put_bit(cs[i], gaps);
        for (int i = 7; i >= 0; i--) put_bit(stop_pat[i], gaps);
        put_bit(1'b1, 0);
        put_bit(1'b1, 0);
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic pin_prog();
        @(negedge clk); prog = 1'b1;
        @(negedge clk); prog = 1'b0;
    endtask

    task automatic host_prog();
        @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h01;
        @(negedge clk); reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic status_is(input int code, input string req);
        @(negedge clk);
        reg_addr = 1'b0;
        #1;
        chk(int'(err_code) == code, req, int'(err_code), code);
        chk(reg_rdata == {6'b0, code[1:0]}, "R9 status read", int'(reg_rdata), code);
        chk(init_n == (code == 0), req, int'(init_n), int'(code == 0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R1 watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(init_n == 1'b1, "R1 init_n", int'(init_n), 1);
        chk(frame_ok == 1'b0, "R1 frame_ok", int'(frame_ok), 0);
        status_is(0, "R1 reset status");

        // R2, R3, R6: good data frame with a doubled zero before the start
        send_frame(2'b00, 40'h12_34_56_78_9A, 8'h00, 8'hFF, 0, 1, 0);
        // R11: address frame with stalls everywhere
        send_frame(2'b01, 40'hFF_00_A5_5A_3C, 8'h00, 8'hFF, 1, 0, 0);
        // R4: identity frame with the right code
        send_frame(2'b10, 40'hC3_A5_11_22_33, 8'h00, 8'hFF, 0, 0, 0);
        // R4: data frame whose leading bytes differ from the code
        send_frame(2'b00, 40'h00_01_02_03_04, 8'h00, 8'hFF, 0, 0, 0);
        status_is(0, "R6 no error after passes");

        // R4: wrong identity code
        send_frame(2'b10, 40'hC3_A4_11_22_33, 8'h00, 8'hFF, 0, 0, 1);
        status_is(1, "R7 halted on id");
        // R7: further frames ignored, code kept
        send_frame(2'b00, 40'h12_34_56_78_9A, 8'h00, 8'hFF, 0, 0, -1);
        send_frame(2'b00, 40'h12_34_56_78_9A, 8'h11, 8'hFF, 0, 0, -1);
        status_is(1, "R7 first error kept");
        // R8: prog pin clears
        pin_prog();
        status_is(0, "R8 prog clears");

        // R3: bad checksum, then R9 host restart
        send_frame(2'b00, 40'hDE_AD_BE_EF_01, 8'h40, 8'hFF, 0, 0, 3);
        status_is(3, "R3 checksum latched");
        host_prog();
        status_is(0, "R9 host program clears");

        // R10: id and checksum both wrong
        send_frame(2'b10, 40'h00_00_11_22_33, 8'h01, 8'hFF, 0, 0, 3);
        status_is(3, "R10 checksum wins");
        pin_prog();

        // R5: stop run with a zero, caught at the next start pair
        send_frame(2'b01, 40'h01_02_03_04_05, 8'h00, 8'hF7, 0, 0, 0);
        status_is(0, "R5 no error before next start");
        send_frame(2'b00, 40'h12_34_56_78_9A, 8'h00, 8'hFF, 0, 0, 2);
        status_is(2, "R5 alignment latched");
        pin_prog();

        // R8: restart forgets a bad stop run
        send_frame(2'b00, 40'hAA_BB_CC_DD_EE, 8'h00, 8'h7F, 0, 0, 0);
        pin_prog();
        send_frame(2'b00, 40'h12_34_56_78_9A, 8'h00, 8'hFF, 1, 0, 0);
        status_is(0, "R8 stop record cleared");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
        finish_run();
    end
endmodule